// File: doc/BRIEF.md
# Late-Resolving Branch Squash Controller

This block runs the control-flow side of a five-stage in-order pipeline with the stages fetch, decode, execute, memory and writeback. It owns the program counter, drives the address port of a combinational instruction memory, and moves each fetched word through valid-qualified stage registers. The datapath outside reads the per-stage instruction buses. The only control transfer it understands is a conditional equality branch. The datapath's ALU compares the two source registers while the branch sits in execute and returns a zero flag. The controller turns that flag into a registered redirect, and the redirect takes effect while the branch occupies the memory stage.

Because the outcome is late, three sequentially fetched words are already inside the pipeline when a taken branch redirects fetch. The controller turns each of them into the all-zero no-op before it can reach the memory or writeback stage, so none of them writes state. Fetch then resumes at the target, and the word fetched there always runs. A not-taken branch disturbs nothing. A free-running cycle count and a running total of squashed words are exposed so that the cost of each taken branch can be measured at the ports.

Top module: `bsq_ctrl`

## Requirements
- R1: While reset is asserted and on its release, the fetch address equals the RESET_VEC parameter, every stage is empty, every stage instruction bus reads zero, the redirect select is low, and both counters read zero.
- R2: In any cycle where the redirect select is low, the next fetch address is the current fetch address plus 4.
- R3: A word is a branch when bits [31:26] equal 6'h04. A branch that is valid in execute while ex_zero is high raises the redirect select in the next cycle, which is the cycle the branch spends in the memory stage. The select is high in no other cycle.
- R4: When the select is high, the next fetch address is the branch address plus 4, plus 4 times the sign-extended immediate held in bits [15:0]. Negative immediates therefore branch backward.
- R5: A taken branch empties the three stages behind it at once. The words from branch+4, branch+8 and branch+12 never retire at writeback.
- R6: The first word fetched from a taken target travels down the pipeline and retires.
- R7: A branch whose zero flag is low causes no squash, and the three words that follow it retire in order.
- R8: A branch that sits in a squashed slot never raises the select and never changes the fetch address.
- R9: The cycle counter advances by one on every clock out of reset. The squash counter advances by exactly 3 for each taken branch and is otherwise unchanged.
- R10: A stage that holds no valid word presents the all-zero no-op encoding on its instruction bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| imem_addr | output | AW | Fetch address (the program counter) |
| imem_rdata | input | IW | Instruction word at imem_addr, same cycle |
| ex_zero | input | 1 | ALU zero flag for the word in execute |
| pc_sel | output | 1 | Redirect select: fetch from the branch target next |
| d_instr | output | IW | Decode-stage word, zero when empty |
| x_instr | output | IW | Execute-stage word, zero when empty |
| m_instr | output | IW | Memory-stage word, zero when empty |
| w_instr | output | IW | Writeback-stage word, zero when empty |
| w_pc | output | AW | Address of the writeback-stage word |
| w_valid | output | 1 | Writeback stage holds a live word |
| cycle_cnt | output | CW | Clocks since reset |
| squash_cnt | output | CW | Total of nullified words |

## Verification
A stale or missing valid bit shows up within at most three clocks, in one of two ways: a zero word appears at writeback where a live one belonged, or a word from a wrong-path address retires. A wrong target computation moves imem_addr in the cycle right after the select pulse. If a squash fails to clear the registered outcome, a second select pulse appears one cycle later, along with a fetch address no correct program path reaches. The bench follows the retired address stream, the fetch address and both counters every clock, so any of these errors surfaces within a few cycles of the branch that caused it.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
   // stage order after fetch; index 0 is decode
   typedef enum logic [1:0] {
      STG_DEC = 2'd0,
      STG_EXE = 2'd1,
      STG_MEM = 2'd2,
      STG_WB  = 2'd3
   } stage_e;

   localparam int unsigned NUM_STAGES   = 4;
   // slots behind a branch that is resolved in the memory stage
   localparam int unsigned SQUASH_DEPTH = 3;
endpackage

// File: rtl/bsq_fetch.sv
module bsq_fetch #(
   parameter int unsigned    AW        = 32,
   parameter logic [AW-1:0]  RESET_VEC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          redirect,
   input  logic [AW-1:0] target,
   output logic [AW-1:0] pc
);
   localparam logic [AW-1:0] STEP = AW'(4);

   if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
      $error("RESET_VEC must be word aligned");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pc <= RESET_VEC;
      else if (redirect) pc <= target;
      else               pc <= pc + STEP;
   end
endmodule

// File: rtl/bsq_resolve.sv
module bsq_resolve #(
   parameter int unsigned      AW      = 32,
   parameter int unsigned      IW      = 32,
   parameter int unsigned      IMM_W   = 16,
   parameter int unsigned      OPC_LSB = 26,
   parameter int unsigned      OPC_W   = 6,
   parameter logic [OPC_W-1:0] BR_OPC  = 6'h04
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          x_valid,
   input  logic [IW-1:0] x_instr,
   input  logic [AW-1:0] x_pc,
   input  logic          ex_zero,
   input  logic          kill,
   output logic          m_taken,
   output logic [AW-1:0] m_target
);
   localparam int unsigned EXT_W = AW - IMM_W - 2;

   if (AW <= IMM_W + 2) begin : g_bad_aw
      $error("AW must exceed IMM_W + 2");
   end
   if (OPC_LSB + OPC_W > IW) begin : g_bad_opc
      $error("opcode field outside the instruction word");
   end

   logic          is_br;
   logic [AW-1:0] ofs;
   logic [AW-1:0] tgt;

   assign is_br = x_valid && (x_instr[OPC_LSB +: OPC_W] == BR_OPC);
   assign ofs   = {{EXT_W{x_instr[IMM_W-1]}}, x_instr[IMM_W-1:0], 2'b00};
   assign tgt   = x_pc + AW'(4) + ofs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_taken  <= 1'b0;
         m_target <= '0;
      end else begin
         m_taken  <= is_br && ex_zero && !kill;
         m_target <= tgt;
      end
   end

   // a branch caught in a squashed execute slot must not resolve (R8)
   p_killed_branch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      kill |=> !m_taken);
   // an outcome never lasts two cycles, since the slot behind is squashed (R3)
   p_single_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      m_taken |=> !m_taken);
endmodule

// File: rtl/bsq_pipe_regs.sv
module bsq_pipe_regs #(
   parameter int unsigned AW  = 32,
   parameter int unsigned IW  = 32,
   parameter int unsigned NST = bsq_pkg::NUM_STAGES,
   parameter int unsigned KD  = bsq_pkg::SQUASH_DEPTH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    kill,
   input  logic [IW-1:0]           f_instr,
   input  logic [AW-1:0]           f_pc,
   output logic [NST-1:0]          v_q,
   output logic [NST-1:0][IW-1:0]  i_q,
   output logic [NST-1:0][AW-1:0]  p_q
);
   if (KD >= NST) begin : g_bad_depth
      $error("squash depth must leave the writeback stage untouched");
   end

   for (genvar g = 0; g < NST; g++) begin : g_stage
      logic          src_v;
      logic [IW-1:0] src_i;
      logic [AW-1:0] src_p;
      logic          nxt_v;
      logic          r_v;
      logic [IW-1:0] r_i;
      logic [AW-1:0] r_p;

      if (g == 0) begin : g_from_fetch
         assign src_v = 1'b1;
         assign src_i = f_instr;
         assign src_p = f_pc;
      end else begin : g_from_prev
         assign src_v = v_q[g-1];
         assign src_i = i_q[g-1];
         assign src_p = p_q[g-1];
      end

      if (g < KD) begin : g_squashable
         assign nxt_v = src_v && !kill;
      end else begin : g_kept
         assign nxt_v = src_v;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_v <= 1'b0;
            r_i <= '0;
            r_p <= '0;
         end else begin
            r_v <= nxt_v;
            r_i <= nxt_v ? src_i : '0;
            r_p <= src_p;
         end
      end

      assign v_q[g] = r_v;
      assign i_q[g] = r_i;
      assign p_q[g] = r_p;
   end
endmodule

// File: rtl/bsq_counters.sv
module bsq_counters #(
   parameter int unsigned CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          squash,
   input  logic [2:0]    lost,
   output logic [CW-1:0] cycle_cnt,
   output logic [CW-1:0] squash_cnt
);
   logic [CW-1:0] add;
   assign add = squash ? CW'($countones(lost)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cycle_cnt  <= '0;
         squash_cnt <= '0;
      end else begin
         cycle_cnt  <= cycle_cnt + CW'(1);
         squash_cnt <= squash_cnt + add;
      end
   end
endmodule

// File: rtl/bsq_ctrl.sv
module bsq_ctrl #(
   parameter int unsigned      AW        = 32,
   parameter int unsigned      IW        = 32,
   parameter int unsigned      IMM_W     = 16,
   parameter int unsigned      OPC_LSB   = 26,
   parameter int unsigned      OPC_W     = 6,
   parameter logic [OPC_W-1:0] BR_OPC    = 6'h04,
   parameter int unsigned      CW        = 32,
   parameter logic [AW-1:0]    RESET_VEC = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] imem_addr,
   input  logic [IW-1:0] imem_rdata,
   input  logic          ex_zero,
   output logic          pc_sel,
   output logic [IW-1:0] d_instr,
   output logic [IW-1:0] x_instr,
   output logic [IW-1:0] m_instr,
   output logic [IW-1:0] w_instr,
   output logic [AW-1:0] w_pc,
   output logic          w_valid,
   output logic [CW-1:0] cycle_cnt,
   output logic [CW-1:0] squash_cnt
);
   import bsq_pkg::*;

   localparam int unsigned NST = NUM_STAGES;

   logic [NST-1:0]         v_q;
   logic [NST-1:0][IW-1:0] i_q;
   logic [NST-1:0][AW-1:0] p_q;
   logic [AW-1:0]          m_target;
   logic                   m_taken;

   bsq_fetch #(.AW(AW), .RESET_VEC(RESET_VEC)) u_fetch (
      .clk(clk), .rst_n(rst_n), .redirect(pc_sel),
      .target(m_target), .pc(imem_addr)
   );

   bsq_pipe_regs #(.AW(AW), .IW(IW), .NST(NST), .KD(SQUASH_DEPTH)) u_pipe (
      .clk(clk), .rst_n(rst_n), .kill(pc_sel),
      .f_instr(imem_rdata), .f_pc(imem_addr),
      .v_q(v_q), .i_q(i_q), .p_q(p_q)
   );

   bsq_resolve #(.AW(AW), .IW(IW), .IMM_W(IMM_W), .OPC_LSB(OPC_LSB),
                 .OPC_W(OPC_W), .BR_OPC(BR_OPC)) u_resolve (
      .clk(clk), .rst_n(rst_n),
      .x_valid(v_q[STG_EXE]), .x_instr(i_q[STG_EXE]), .x_pc(p_q[STG_EXE]),
      .ex_zero(ex_zero), .kill(pc_sel),
      .m_taken(m_taken), .m_target(m_target)
   );

   // fetch slot is always live out of reset
   bsq_counters #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .squash(pc_sel),
      .lost({1'b1, v_q[STG_DEC], v_q[STG_EXE]}),
      .cycle_cnt(cycle_cnt), .squash_cnt(squash_cnt)
   );

   assign pc_sel  = m_taken;
   assign d_instr = i_q[STG_DEC];
   assign x_instr = i_q[STG_EXE];
   assign m_instr = i_q[STG_MEM];
   assign w_instr = i_q[STG_WB];
   assign w_pc    = p_q[STG_WB];
   assign w_valid = v_q[STG_WB];

   p_sel_in_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel |-> v_q[STG_MEM]);
   p_seq_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_sel |=> imem_addr == $past(imem_addr) + AW'(4));
   p_redirect_r4: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel |=> imem_addr == $past(m_target));
   p_squash_three_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel |=> !v_q[STG_DEC] && !v_q[STG_EXE] && !v_q[STG_MEM]);
   p_target_runs_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(pc_sel) |=> v_q[STG_DEC]);
   p_squash_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pc_sel |=> squash_cnt == $past(squash_cnt) + CW'(3));
   p_empty_is_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !w_valid |-> w_instr == '0);
endmodule

// File: tb/sim_bsq_ctrl.sv
module sim_bsq_ctrl;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] imem_addr, imem_rdata;
   logic        ex_zero, pc_sel, w_valid;
   logic [31:0] d_instr, x_instr, m_instr, w_instr, w_pc, cycle_cnt, squash_cnt;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   // program: branches at 0x10 (taken, +5), 0x14 (would be taken, +20),
   // 0x28 (not taken), 0x40 (taken, -5 -> loop back to 0x30)
   function automatic logic [31:0] prog(input logic [31:0] a);
      case (a)
         32'h10:  return {6'h04, 5'd1, 5'd1, 16'd5};
         32'h14:  return {6'h04, 5'd2, 5'd2, 16'd20};
         32'h28:  return {6'h04, 5'd1, 5'd2, 16'd3};
         32'h40:  return {6'h04, 5'd3, 5'd3, 16'hFFFB};
         default: return {6'h0C, a[27:2]};
      endcase
   endfunction

   function automatic bit alu_zero(input logic [31:0] w);
      return w[25:21] == w[20:16];
   endfunction

   assign imem_rdata = prog(imem_addr);
   assign ex_zero    = alu_zero(x_instr);

   bsq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_rdata(imem_rdata),
      .ex_zero(ex_zero), .pc_sel(pc_sel), .d_instr(d_instr), .x_instr(x_instr),
      .m_instr(m_instr), .w_instr(w_instr), .w_pc(w_pc), .w_valid(w_valid),
      .cycle_cnt(cycle_cnt), .squash_cnt(squash_cnt)
   );

   // behavioural reference: fetch pc, four slots, pending outcome
   logic [31:0] f_pc;
   logic [31:0] s_pc[4];
   bit          s_v[4];
   bit          m_tk;
   logic [31:0] m_tg;
   int          e_cyc, e_sq;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      f_pc = 32'h0; m_tk = 1'b0; m_tg = 32'h0; e_cyc = 0; e_sq = 0;
      for (int k = 0; k < 4; k++) begin s_v[k] = 1'b0; s_pc[k] = 32'h0; end
   endtask

   task automatic model_step();
      bit          red = s_v[2] && m_tk;
      logic [31:0] old_tg = m_tg;
      logic [31:0] xw = prog(s_pc[1]);
      logic [31:0] ofs = {{14{xw[15]}}, xw[15:0], 2'b00};
      m_tk = !red && s_v[1] && (xw[31:26] == 6'h04) && alu_zero(xw);
      m_tg = s_pc[1] + 32'd4 + ofs;
      s_v[3] = s_v[2];          s_pc[3] = s_pc[2];
      s_v[2] = s_v[1] && !red;  s_pc[2] = s_pc[1];
      s_v[1] = s_v[0] && !red;  s_pc[1] = s_pc[0];
      s_v[0] = !red;            s_pc[0] = f_pc;
      f_pc = red ? old_tg : f_pc + 32'd4;
      e_cyc++;
      if (red) e_sq += 3;
   endtask

   int ret28 = 0, ret2c = 0, ret30 = 0, wrong = 0, taken = 0;

   task automatic compare();
      chk("R2/R4 fetch address", imem_addr, f_pc);
      chk("R3 redirect select", {31'b0, pc_sel}, {31'b0, m_tk && s_v[2]});
      chk("R5/R7 writeback valid", {31'b0, w_valid}, {31'b0, s_v[3]});
      chk("R10 writeback word", w_instr, s_v[3] ? prog(s_pc[3]) : 32'h0);
      chk("R10 execute word", x_instr, s_v[1] ? prog(s_pc[1]) : 32'h0);
      if (s_v[3]) chk("R5 writeback address", w_pc, s_pc[3]);
      chk("R9 cycle count", cycle_cnt, e_cyc);
      chk("R9 squash count", squash_cnt, e_sq);
      if (pc_sel) taken++;
      if (w_valid) begin
         if (w_pc == 32'h28) ret28++;
         if (w_pc == 32'h2C) ret2c++;
         if (w_pc == 32'h30) ret30++;
         if (w_pc == 32'h14 || w_pc == 32'h18 || w_pc == 32'h44) wrong++;
      end
      if (imem_addr == 32'h68) wrong++;
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset fetch address", imem_addr, 32'h0);
      chk("R1 reset writeback valid", {31'b0, w_valid}, 32'h0);
      chk("R1 reset select", {31'b0, pc_sel}, 32'h0);
      chk("R1 reset decode word", d_instr, 32'h0);
      chk("R1 reset memory word", m_instr, 32'h0);
      chk("R1 reset counters", cycle_cnt | squash_cnt, 32'h0);
      rst_n = 1'b1;
      for (int c = 0; c < 400; c++) begin
         model_step();
         @(negedge clk);
         compare();
      end
      chk("R6 target word 0x28 retired", {31'b0, ret28 > 0}, 32'h1);
      chk("R7 word after not-taken branch retired", {31'b0, ret2c > 0}, 32'h1);
      chk("R4 backward target 0x30 retired", {31'b0, ret30 > 1}, 32'h1);
      chk("R5/R8 wrong-path words seen", wrong, 32'h0);
      chk("R9 squash total vs taken", squash_cnt, taken * 3);
      done = 1'b1;
   end

   initial begin
      fork
         begin
            #(100000 * 10);
            if (!done) begin
               n_tests++; n_fail++;
               $display("FAIL watchdog: run hung actual=running expected=done");
            end
         end
         wait (done);
      join_any
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule